// File: doc/BRIEF.md
# Configurable Tick Timer with Clock Selection and Stop Control

This block is a timer/counter core controlled by a 32-bit control word and a compare word, both reached through a small write/read register port. The control word chooses where count ticks come from. They come either from a fixed-ratio prescaler running on the system clock, or from an asynchronous external clock pin that is synchronized and edge-detected on a selectable polarity. The control word also chooses the operating mode. It sets whether a stop also clears the count, and whether the count is enabled at all.

In interval mode the counter climbs to the compare value, returns to zero on the next tick and raises a one-cycle terminal flag. In pulse mode the counter runs freely and wraps at its width. In watchdog mode, software cannot halt the count by clearing the enable bit. Only the external watchdog-disable input stops it. The fourth mode code is reserved and holds the counter.

Top module: `tick_timer`

## Requirements
- R1: After reset the control word reads 0, the compare word reads all ones within its CW bits, the count is 0 and the terminal flag is low.
- R2: Control bits 31:8 and bit 4 ignore writes and always read 0, and compare bits above CW read 0. Field positions are: bit 7 enable, bit 6 divider enable, bit 5 clear-on-stop, bit 3 edge polarity, bit 2 source select, bits 1:0 mode. Register address 0 is control and address 1 is compare.
- R3: With enable 1 the count advances by one per tick. A write that takes enable from 1 to 0 with clear-on-stop 0 stops the count and holds its value.
- R4: A write that takes enable from 1 to 0 while clear-on-stop is 1 stops the count and sets it to 0 on that write's clock edge.
- R5: Writing clear-on-stop from 0 to 1 while enable is already 0 leaves the count unchanged.
- R6: From enable=1 and clear-on-stop=0, a single write of enable=0 and clear-on-stop=1 stops the count and clears it to 0.
- R7: With source select 0 and divider enable 1, the count advances once every DIV system clocks. With divider enable 0 it does not advance.
- R8: With source select 1, each external edge of the chosen polarity advances the count by exactly one. Polarity 1 selects rising edges and polarity 0 selects falling edges. Edges of the other polarity have no effect.
- R9: In mode 00 (interval), a tick that finds the count equal to the compare value reloads the count to 0 and pulses termPulse for exactly that one cycle.
- R10: In mode 10 (watchdog), once started with enable 1, a write of enable 0 reads back 0 but counting continues. While wdDisable is high the count holds.
- R11: In mode 01 (pulse) the count runs past the compare value without reloading. In mode 11 (reserved) the count does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 1 | Register select: 0 control, 1 compare |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Read data of the register selected by regAddr |
| extClk | input | 1 | Asynchronous external count clock |
| wdDisable | input | 1 | Halts counting in watchdog mode |
| countVal | output | CW | Current count |
| termPulse | output | 1 | One-cycle flag on interval reload |

## Verification
The bench builds the block with CW=8 and DIV=4. With a prescaler tick every four clocks, the tick times are exact multiples of four clocks after a control write. The bench sweeps compare values 0 through 4 over more than two full reload periods each, so it reaches the compare-equals-zero case, where every tick both reloads and flags. The eight-bit width keeps the reserved-bit masking of the compare word visible. Short external pulses cover both edge polarities and show that an edge of the unselected polarity leaves the count unchanged.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  typedef enum logic [1:0] {
    MODE_INTERVAL = 2'b00,
    MODE_PULSE    = 2'b01,
    MODE_WATCHDOG = 2'b10,
    MODE_RSVD     = 2'b11
  } tmrMode_t;

  localparam int BIT_EN    = 7;
  localparam int BIT_DIV   = 6;
  localparam int BIT_CLR   = 5;
  localparam int BIT_EDGE  = 3;
  localparam int BIT_SRC   = 2;

  typedef struct packed {
    logic inc;
    logic clr;
    logic wrapAtCmp;
  } tmrStrobe_t;

endpackage

// File: rtl/tick_timer_ctrl.sv
module tick_timer_ctrl
  import tick_timer_pkg::*;
#(
  parameter int CW  = 16,
  parameter int DIV = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWe,
  input  logic          regAddr,
  input  logic [31:0]   regWdata,
  input  logic          extClk,
  input  logic          wdDisable,
  output tmrStrobe_t    strobe,
  output logic [7:0]    ctrlBits,
  output logic [CW-1:0] cmpVal
);

  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] PRESC_LAST = PW'(DIV - 1);

  logic cntEn, divEn, clrOnStop, edgeRise, extSel, armed;
  tmrMode_t mode;
  logic [1:0] syncQ;
  logic extPrev;
  logic [PW-1:0] presc;

  logic ctrlWr, cmpWr, extEdge, prescTick, tick, run;
  tmrMode_t wrMode;
  logic unusedWdata;

  assign ctrlWr = regWe & ~regAddr;
  assign cmpWr  = regWe & regAddr;
  assign wrMode = tmrMode_t'(regWdata[1:0]);
  assign unusedWdata = ^regWdata;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntEn     <= 1'b0;
      divEn     <= 1'b0;
      clrOnStop <= 1'b0;
      edgeRise  <= 1'b0;
      extSel    <= 1'b0;
      mode      <= MODE_INTERVAL;
      cmpVal    <= '1;
    end else begin
      if (ctrlWr) begin
        cntEn     <= regWdata[BIT_EN];
        divEn     <= regWdata[BIT_DIV];
        clrOnStop <= regWdata[BIT_CLR];
        edgeRise  <= regWdata[BIT_EDGE];
        extSel    <= regWdata[BIT_SRC];
        mode      <= wrMode;
      end
      if (cmpWr) cmpVal <= regWdata[CW-1:0];
    end
  end

  // Watchdog run latch: started by an enabling write, only the disable pin or a mode change stops it.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else if (wdDisable || (ctrlWr && wrMode != MODE_WATCHDOG)) armed <= 1'b0;
    else if (ctrlWr && regWdata[BIT_EN]) armed <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ   <= '0;
      extPrev <= 1'b0;
    end else begin
      syncQ   <= {syncQ[0], extClk};
      extPrev <= syncQ[1];
    end
  end

  assign extEdge = edgeRise ? (syncQ[1] & ~extPrev) : (~syncQ[1] & extPrev);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) presc <= '0;
    else if (!divEn || presc == PRESC_LAST) presc <= '0;
    else presc <= presc + 1'b1;
  end

  assign prescTick = divEn && (presc == PRESC_LAST);
  assign tick      = extSel ? extEdge : prescTick;

  always_comb begin
    unique case (mode)
      MODE_WATCHDOG: run = armed & ~wdDisable;
      MODE_RSVD:     run = 1'b0;
      default:       run = cntEn;
    endcase
  end

  assign strobe.inc       = run & tick;
  assign strobe.clr       = ctrlWr && cntEn && !regWdata[BIT_EN] && regWdata[BIT_CLR]
                            && (wrMode != MODE_WATCHDOG);
  assign strobe.wrapAtCmp = (mode == MODE_INTERVAL);

  assign ctrlBits = {cntEn, divEn, clrOnStop, 1'b0, edgeRise, extSel, mode};

endmodule

// File: rtl/tick_timer_dp.sv
module tick_timer_dp
  import tick_timer_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  tmrStrobe_t    strobe,
  input  logic [CW-1:0] cmpVal,
  output logic [CW-1:0] countVal,
  output logic          termPulse
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countVal  <= '0;
      termPulse <= 1'b0;
    end else begin
      termPulse <= 1'b0;
      if (strobe.clr) begin
        countVal <= '0;
      end else if (strobe.inc) begin
        if (strobe.wrapAtCmp && countVal == cmpVal) begin
          countVal  <= '0;
          termPulse <= 1'b1;
        end else begin
          countVal <= countVal + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int CW  = 16,
  parameter int DIV = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWe,
  input  logic          regAddr,
  input  logic [31:0]   regWdata,
  output logic [31:0]   regRdata,
  input  logic          extClk,
  input  logic          wdDisable,
  output logic [CW-1:0] countVal,
  output logic          termPulse
);

  tmrStrobe_t    strobe;
  logic [7:0]    ctrlBits;
  logic [CW-1:0] cmpVal;

  tick_timer_ctrl #(.CW(CW), .DIV(DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .extClk(extClk), .wdDisable(wdDisable), .strobe(strobe), .ctrlBits(ctrlBits),
    .cmpVal(cmpVal)
  );

  tick_timer_dp #(.CW(CW)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmpVal(cmpVal),
    .countVal(countVal), .termPulse(termPulse)
  );

  assign regRdata = regAddr ? 32'(cmpVal) : {24'd0, ctrlBits};

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic          regWe,
  input logic          regAddr,
  input logic [31:0]   regWdata,
  input logic [31:0]   regRdata,
  input logic          wdDisable,
  input logic [7:0]    ctrlBits,
  input logic [CW-1:0] countVal,
  input logic          termPulse
);

  p_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (countVal != $past(countVal)) |-> (countVal == $past(countVal) + 1'b1 || countVal == '0));

  p_hold_stopped_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlBits[7] && ctrlBits[1:0] != 2'b10 && !regWe) |=> $stable(countVal));

  // R6 is the same transition written in one access
  p_stop_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && !regAddr && ctrlBits[7] && !regWdata[7] && regWdata[5] && regWdata[1:0] != 2'b10)
    |=> (countVal == '0));

  p_late_clr_r5: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && !regAddr && !ctrlBits[7] && !regWdata[7] && ctrlBits[1:0] != 2'b10)
    |=> $stable(countVal));

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    !regAddr |-> (regRdata[31:8] == 24'd0 && !regRdata[4]));

  p_div_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlBits[2] && !ctrlBits[6] && !regWe) |=> $stable(countVal));

  p_term_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    termPulse |-> (countVal == '0));

  p_wd_halt_r10: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlBits[1:0] == 2'b10 && wdDisable && !regWe) |=> $stable(countVal));

  p_rsvd_mode_r11: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlBits[1:0] == 2'b11 && !regWe) |=> $stable(countVal));

endmodule

bind tick_timer tick_timer_chk #(.CW(CW)) u_chk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
  .regRdata(regRdata), .wdDisable(wdDisable), .ctrlBits(ctrlBits),
  .countVal(countVal), .termPulse(termPulse)
);

// File: tb/tick_timer_test.sv
module tick_timer_test;

  localparam int CLK_PERIOD = 10;
  localparam int CW  = 8;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0;
  logic regAddr = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic extClk = 1'b0;
  logic wdDisable = 1'b0;
  logic [CW-1:0] countVal;
  logic termPulse;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tick_timer #(.CW(CW), .DIV(DIV)) uut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .extClk(extClk), .wdDisable(wdDisable),
    .countVal(countVal), .termPulse(termPulse)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrReg(input logic a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0; regWdata = '0;
  endtask

  task automatic rdReg(input logic a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic clearCount();
    wrReg(1'b0, 32'hA0);
    wrReg(1'b0, 32'h20);
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    finishRun();
  end

  initial begin
    logic [31:0] d;
    logic [CW-1:0] v;
    waitClk(3);
    rstN = 1'b1;
    waitClk(2);

    // R1 reset state
    rdReg(1'b0, d); chk("R1 ctrl", d, 32'h0);
    rdReg(1'b1, d); chk("R1 cmp", d, 32'hFF);
    chk("R1 count", 32'(countVal), 32'h0);
    chk("R1 term", 32'(termPulse), 32'h0);

    // R2 reserved bits
    wrReg(1'b0, 32'hFFFF_FFFF);
    rdReg(1'b0, d); chk("R2 ctrl", d, 32'hEF);
    wrReg(1'b1, 32'hFFFF_FF3C);
    rdReg(1'b1, d); chk("R2 cmp", d, 32'h3C);
    chk("R11 reserved mode holds", 32'(countVal), 32'h0);

    // R7 internal prescaled ticks
    clearCount();
    wrReg(1'b1, 32'hFF);
    wrReg(1'b0, 32'hC0);
    for (int k = 1; k <= 6; k++) begin
      waitClk(DIV);
      chk("R7 div tick", 32'(countVal), 32'(k));
    end
    wrReg(1'b0, 32'h80);
    v = countVal;
    waitClk(12);
    chk("R7 div off", 32'(countVal), 32'(v));

    // R3 stop and hold
    wrReg(1'b0, 32'hC0);
    waitClk(8);
    wrReg(1'b0, 32'h40);
    v = countVal;
    chk("R3 counted", 32'(v != 0), 32'h1);
    waitClk(8);
    chk("R3 hold", 32'(countVal), 32'(v));
    // R5 late clear-on-stop
    wrReg(1'b0, 32'h60);
    waitClk(4);
    chk("R5 no clear", 32'(countVal), 32'(v));
    // R4 stop with clear-on-stop set
    wrReg(1'b0, 32'hE0);
    waitClk(8);
    chk("R4 running", 32'(countVal != 0), 32'h1);
    wrReg(1'b0, 32'h60);
    chk("R4 cleared", 32'(countVal), 32'h0);
    // R6 simultaneous
    wrReg(1'b0, 32'hC0);
    waitClk(8);
    chk("R6 running", 32'(countVal != 0), 32'h1);
    wrReg(1'b0, 32'h60);
    chk("R6 cleared", 32'(countVal), 32'h0);

    // R9 interval sweep
    for (int c = 0; c <= 4; c++) begin
      clearCount();
      wrReg(1'b1, 32'(c));
      wrReg(1'b0, 32'hC0);
      for (int n = 1; n <= 2 * (c + 1) + 1; n++) begin
        waitClk(DIV);
        chk("R9 count", 32'(countVal), 32'(n % (c + 1)));
        chk("R9 term", 32'(termPulse), 32'((n % (c + 1)) == 0));
      end
    end
    waitClk(1);
    chk("R9 term one cycle", 32'(termPulse), 32'h0);

    // R8 external rising
    clearCount();
    wrReg(1'b1, 32'hFF);
    wrReg(1'b0, 32'h8C);
    for (int n = 1; n <= 4; n++) begin
      extClk = 1'b1; waitClk(4);
      chk("R8 rise", 32'(countVal), 32'(n));
      extClk = 1'b0; waitClk(4);
      chk("R8 rise ignores fall", 32'(countVal), 32'(n));
    end
    // R8 external falling
    clearCount();
    wrReg(1'b0, 32'h84);
    for (int n = 1; n <= 4; n++) begin
      extClk = 1'b1; waitClk(4);
      chk("R8 fall ignores rise", 32'(countVal), 32'(n - 1));
      extClk = 1'b0; waitClk(4);
      chk("R8 fall", 32'(countVal), 32'(n));
    end

    // R10 watchdog
    clearCount();
    wrReg(1'b0, 32'hC2);
    waitClk(8);
    wrReg(1'b0, 32'h42);
    rdReg(1'b0, d); chk("R10 enable reads 0", d, 32'h42);
    v = countVal;
    waitClk(8);
    chk("R10 keeps counting", 32'(countVal), 32'(v + 8'd2));
    wdDisable = 1'b1;
    v = countVal;
    waitClk(12);
    chk("R10 disable halts", 32'(countVal), 32'(v));
    wdDisable = 1'b0;

    // R11 pulse mode passes compare, reserved mode holds
    clearCount();
    wrReg(1'b1, 32'h2);
    wrReg(1'b0, 32'hC1);
    waitClk(DIV * 5);
    chk("R11 pulse no reload", 32'(countVal), 32'h5);
    wrReg(1'b0, 32'hC3);
    v = countVal;
    waitClk(12);
    chk("R11 reserved holds", 32'(countVal), 32'(v));

    finishRun();
  end

endmodule